// File: doc/BRIEF.md
# Time-Base Strobe and Slow-Clock Enable Generator

This block produces a roughly 1 MHz time-base enable strobe for timer and delay logic. It also produces a clock enable that slows the system clock, and it drives one output pin that has two roles. Everything runs in a single system clock domain. The two candidate source clocks arrive as enable pulses in that domain: `main_ce` for the main clock input and `aux_ce` for the multifunction pin that carries a 14.31818 MHz crystal. One 8-bit configuration register sets the behaviour. Its bits [2:0] select the time-base divide ratio. Bit 3 selects the source. Bits [6:4] select the slow-mode ratio. Bit 7 selects the pin role.

The ratios of the time-base divider are not powers of two (14, 24, 32, 40 and 48). This lets the block reach about 1 MHz from several crystal frequencies. When the main source is selected and the double-speed input is high, an extra divide-by-two stage comes first. The slow-clock enable stays high at full speed. In slow mode it pulses once every 2, 4, 6 or 8 clocks. The pin carries either the active-low stop-clock request or a full-speed/reduced-speed indicator that an external clock generator can follow.

Top module: `tbclk_gen`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00 and `tb_strobe` is low. `sys_ce` is high while `slow_mode` is low, and `pin_out` equals the inverse of `stop_req`.
- R2: Divider field codes 000, 001, 010, 011 and 100 make `tb_strobe` pulse once for every 24, 32, 40, 48 and 14 counted source pulses, in that order.
- R3: The reserved divider codes 101, 110 and 111 divide by 24.
- R4: When bit 3 is 1, only `aux_ce` pulses are counted. When bit 3 is 0, only `main_ce` pulses are counted.
- R5: When bit 3 is 0 and `dbl_mode` is high, only every second `main_ce` pulse is counted. When bit 3 is 1, `dbl_mode` has no effect.
- R6: `tb_strobe` is high for exactly one clock. It rises in the clock that follows the clock in which the terminal source pulse arrived.
- R7: A write (`cfg_wr` high) loads `cfg_wdata`, and `cfg_rdata` shows the new value in the next clock. The write clears the divider count and the halving stage. A source pulse in the clock of the write is ignored.
- R8: When `slow_mode` is high and slow codes 001, 010, 011 or 100 are selected, `sys_ce` pulses once every 2, 4, 6 or 8 clocks. The first pulse comes in the N-th clock of the slow period.
- R9: When `slow_mode` is high and slow code 000 or a reserved slow code (101, 110, 111) is selected, `sys_ce` stays high.
- R10: When `slow_mode` is low, `sys_ce` is high.
- R11: When bit 7 is 0, `pin_out` equals the inverse of `stop_req` (the active-low stop-clock output).
- R12: When bit 7 is 1, `pin_out` is 1 at effective full speed (R9, R10) and 0 at reduced speed. `stop_req` then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_ce | input | 1 | One-clock pulse per edge of the main clock input |
| aux_ce | input | 1 | One-clock pulse per edge of the 14.31818 MHz pin clock |
| dbl_mode | input | 1 | Main clock input is running at twice its rate |
| slow_mode | input | 1 | Slow mode requested |
| stop_req | input | 1 | Stop-clock request, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current configuration |
| tb_strobe | output | 1 | Time-base enable strobe, about 1 MHz |
| sys_ce | output | 1 | System clock enable (slow-clock divider) |
| pin_out | output | 1 | Stop-clock output or speed indicator |

## Verification
The bench drives every divider code, including the reserved ones, with dense source patterns and with sparse ones. A design that decoded the reserved codes as anything other than 24 would place its strobes at the wrong clocks. A design with a terminal count off by one would drift by one clock every period. Writes arrive in the middle of a count while a source pulse is present. A design that kept the old count or the halving phase, or that counted the pulse in the write clock, would shift every later strobe. `dbl_mode` is toggled with both sources selected, to catch halving that is wrongly applied to the pin clock. Slow mode is entered and left under every slow code. Stop requests and slow mode are toggled in both pin roles, so a pin that follows `stop_req` in the wrong role, or that treats a reserved code as reduced speed, shows up immediately.

// File: rtl/tbclk_pkg.sv
package tbclk_pkg;

    typedef struct packed {
        logic       pin_speed;  // bit 7: pin role
        logic [2:0] slow_sel;   // bits 6:4
        logic       src_aux;    // bit 3
        logic [2:0] div_sel;    // bits 2:0
    } tbclk_cfg_t;

    // terminal count (ratio - 1) of the time-base divider
    function automatic int unsigned div_last(input logic [2:0] sel);
        case (sel)
            3'b001:  return 31;
            3'b010:  return 39;
            3'b011:  return 47;
            3'b100:  return 13;
            default: return 23;   // 000 and reserved codes
        endcase
    endfunction

    // terminal count of the slow divider; 0 means full speed
    function automatic int unsigned slow_last(input logic [2:0] sel);
        case (sel)
            3'b001:  return 1;
            3'b010:  return 3;
            3'b011:  return 5;
            3'b100:  return 7;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tbclk_src_sel.sv
module tbclk_src_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sel_aux,
    input  logic dbl_mode,
    input  logic main_ce,
    input  logic aux_ce,
    output logic src_ce
);
    typedef struct packed {
        logic half;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.half = 1'b0;
        end else if (!sel_aux && dbl_mode && main_ce) begin
            st_d.half = ~st_q.half;
        end
        if (sel_aux) begin
            src_ce = aux_ce;
        end else if (dbl_mode) begin
            src_ce = main_ce & st_q.half;
        end else begin
            src_ce = main_ce;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbclk_tb_div.sv
module tbclk_tb_div #(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       src_ce,
    input  logic [2:0] div_sel,
    output logic       strobe
);
    import tbclk_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stb;
    } st_t;

    st_t              st_d, st_q;
    logic [CNT_W-1:0] last;
    logic             at_last;

    always_comb begin
        last    = CNT_W'(div_last(div_sel));
        at_last = (st_q.cnt == last);
        st_d    = st_q;
        if (clr) begin
            st_d.cnt = '0;
            st_d.stb = 1'b0;
        end else begin
            st_d.stb = src_ce & at_last;
            if (src_ce) begin
                st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign strobe = st_q.stb;
endmodule

// File: rtl/tbclk_slow_div.sv
module tbclk_slow_div #(
    parameter int SLOW_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       slow_mode,
    input  logic [2:0] slow_sel,
    output logic       sys_ce,
    output logic       full_speed
);
    import tbclk_pkg::*;

    typedef struct packed {
        logic [SLOW_W-1:0] cnt;
    } st_t;

    st_t               st_d, st_q;
    logic [SLOW_W-1:0] last;
    logic              at_last;

    always_comb begin
        last       = SLOW_W'(slow_last(slow_sel));
        full_speed = !slow_mode || (last == '0);
        at_last    = (st_q.cnt == last);
        sys_ce     = full_speed || at_last;
        st_d       = st_q;
        if (clr || full_speed) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbclk_gen.sv
module tbclk_gen #(
    parameter int CNT_W  = 6,
    parameter int SLOW_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       main_ce,
    input  logic       aux_ce,
    input  logic       dbl_mode,
    input  logic       slow_mode,
    input  logic       stop_req,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       tb_strobe,
    output logic       sys_ce,
    output logic       pin_out
);
    import tbclk_pkg::*;

    typedef struct packed {
        tbclk_cfg_t cfg;
    } st_t;

    st_t  st_d, st_q;
    logic src_ce;
    logic full_speed;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) st_d.cfg = tbclk_cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tbclk_src_sel u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_wr),
        .sel_aux  (st_q.cfg.src_aux),
        .dbl_mode (dbl_mode),
        .main_ce  (main_ce),
        .aux_ce   (aux_ce),
        .src_ce   (src_ce)
    );

    tbclk_tb_div #(.CNT_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_wr),
        .src_ce  (src_ce),
        .div_sel (st_q.cfg.div_sel),
        .strobe  (tb_strobe)
    );

    tbclk_slow_div #(.SLOW_W(SLOW_W)) u_slow (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cfg_wr),
        .slow_mode  (slow_mode),
        .slow_sel   (st_q.cfg.slow_sel),
        .sys_ce     (sys_ce),
        .full_speed (full_speed)
    );

    always_comb begin
        if (st_q.cfg.pin_speed) pin_out = full_speed;
        else                    pin_out = ~stop_req;
    end

    assign cfg_rdata = st_q.cfg;
endmodule

// File: rtl/tbclk_gen_chk.sv
module tbclk_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slow_mode,
    input logic       stop_req,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       tb_strobe,
    input logic       sys_ce,
    input logic       pin_out
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tb_strobe |=> !tb_strobe); // R6
    AST_WRITE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !tb_strobe); // R7
    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata == $past(cfg_wdata))); // R7
    AST_DIV2_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_mode && cfg_rdata[6:4] == 3'b001 && sys_ce && !cfg_wr)
        |=> (!slow_mode || !sys_ce)); // R8
    AST_SLOW_FULL_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_mode && (cfg_rdata[6:4] == 3'b000 || cfg_rdata[6:4] >= 3'b101))
        |-> sys_ce); // R9
    AST_FAST_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_mode |-> sys_ce); // R10
    AST_PIN_STOP_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[7] |-> (pin_out == !stop_req)); // R11
    AST_PIN_SPEED_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7] && !slow_mode) |-> pin_out); // R12
endmodule

bind tbclk_gen tbclk_gen_chk u_chk (.*);

// File: tb/tb_tbclk_gen.sv
module tb_tbclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_ce = 1'b0, aux_ce = 1'b0, dbl_mode = 1'b0;
    logic       slow_mode = 1'b0, stop_req = 1'b0, cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tb_strobe, sys_ce, pin_out;

    int    total = 0, bad = 0;
    string tag = "R1";
    int    main_p = 1, aux_p = 3, tick = 0;

    // reference state
    int    m_cfg = 0, m_half = 0, m_cnt = 0, m_stb = 0, m_scnt = 0;

    tbclk_gen dut (.*);

    always #10 clk = ~clk;

    function automatic int ratio_of(input int c);
        case (c)
            1: return 32;
            2: return 40;
            3: return 48;
            4: return 14;
            default: return 24;
        endcase
    endfunction

    function automatic int slow_of(input int c);
        case (c)
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic bit m_full();
        return !slow_mode || slow_of((m_cfg >> 4) & 7) == 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 0; m_half = 0; m_cnt = 0; m_stb = 0; m_scnt = 0;
        end else if (cfg_wr) begin
            m_cfg = cfg_wdata; m_half = 0; m_cnt = 0; m_stb = 0; m_scnt = 0;
        end else begin
            bit src;
            int r;
            int n;
            if (m_cfg[3]) src = aux_ce;
            else if (dbl_mode) begin
                src = main_ce && m_half == 1;
                if (main_ce) m_half = 1 - m_half;
            end else src = main_ce;
            r = ratio_of(m_cfg & 7);
            m_stb = (src && m_cnt == r - 1) ? 1 : 0;
            if (src) m_cnt = (m_cnt == r - 1) ? 0 : m_cnt + 1;
            n = slow_of((m_cfg >> 4) & 7);
            if (m_full()) m_scnt = 0;
            else m_scnt = (m_scnt == n - 1) ? 0 : m_scnt + 1;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int exp_ce;
            int exp_pin;
            exp_ce  = m_full() ? 1 : (m_scnt == slow_of((m_cfg >> 4) & 7) - 1);
            exp_pin = m_cfg[7] ? int'(m_full()) : int'(!stop_req);
            chk("cfg_rdata", cfg_rdata, m_cfg);
            chk("tb_strobe", tb_strobe, m_stb);
            chk("sys_ce", sys_ce, exp_ce);
            chk("pin_out", pin_out, exp_pin);
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            tick++;
            main_ce = (tick % main_p) == 0;
            aux_ce  = (tick % aux_p) == 0;
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        #1;
        cfg_wr = 1'b1; cfg_wdata = v;
        main_ce = 1'b1; aux_ce = 1'b1;   // pulse in the write clock: ignored (R7)
        @(negedge clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    initial begin
        #200000000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        chk("reset cfg_rdata", cfg_rdata, 0);
        chk("reset tb_strobe", tb_strobe, 0);
        chk("reset sys_ce", sys_ce, 1);
        chk("reset pin_out", pin_out, 1);

        tag = "R2 R6";
        main_p = 1; wr(8'h00); step(200);
        main_p = 2;
        for (int c = 1; c <= 4; c++) begin wr(8'(c)); step(220); end
        tag = "R3";
        main_p = 1;
        for (int c = 5; c <= 7; c++) begin wr(8'(c)); step(80); end

        tag = "R4";
        main_p = 1; aux_p = 3; wr(8'h0C); step(150);
        main_p = 5; aux_p = 1; wr(8'h08); step(100);

        tag = "R5";
        dbl_mode = 1'b1; main_p = 1; wr(8'h04); step(120);
        wr(8'h0C); aux_p = 2; step(100);
        dbl_mode = 1'b0; step(20);
        dbl_mode = 1'b1; main_p = 1; wr(8'h04); step(7);

        tag = "R7";
        wr(8'h04); step(9); wr(8'h04); step(40);
        dbl_mode = 1'b0; step(5); wr(8'h00); step(30);

        tag = "R8";
        slow_mode = 1'b1;
        for (int c = 1; c <= 4; c++) begin wr(8'(c << 4)); step(40); end
        slow_mode = 1'b0; step(3); slow_mode = 1'b1; step(17);
        tag = "R9";
        wr(8'h00); step(20);
        for (int c = 5; c <= 7; c++) begin wr(8'(c << 4)); step(20); end
        tag = "R10";
        slow_mode = 1'b0; wr(8'h30); step(20);

        tag = "R11";
        wr(8'h20);
        for (int i = 0; i < 6; i++) begin stop_req = ~stop_req; step(3); end
        slow_mode = 1'b1; stop_req = 1'b1; step(10); stop_req = 1'b0; step(5);

        tag = "R12";
        wr(8'hA0);
        for (int i = 0; i < 6; i++) begin
            stop_req = ~stop_req; step(4);
            slow_mode = ~slow_mode; step(5);
        end
        slow_mode = 1'b1; wr(8'hF0); step(10);
        wr(8'h80); step(10);

        step(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule